// File: doc/BRIEF.md
# Stream-Aware Core Clock-Enable Throttle

This block produces the clock enable for a processor core. The core shares two resources with a pixel streaming engine: its slot on the shared memory and the bus into its local lookup RAM. When a video line is active, the core advances only on cycles where the streamer has taken neither resource. At slow pixel rates the core therefore keeps working at a reduced speed and is not frozen for the whole line. Outside a line the core advances on every clock, subject only to its existing wait enable.

A line is started with a pulse that carries a pixel count, and the pixel period is N clocks. The block counts pixels by itself and drops the busy flag when the last pixel period ends. The core can poll that flag to stay in step with the video. The streamer raises its slot strobe at phase 0 of each pixel period and its lookup strobe at phase 1 mod N. The core is therefore held off on every line cycle when N is 1 or 2, and it gets N-2 free cycles per pixel when N is 3 or more.

Top module: `core_throttle`

## Requirements
- R1: After reset `line_busy` is 0 and `core_ce` equals `wait_en`.
- R2: A `line_start` pulse with a nonzero `line_pixels` value, seen while idle, raises `line_busy` at the next clock edge. `line_busy` then stays high for exactly `line_pixels` × N cycles, where N is `div_n` and a value of 0 counts as 1.
- R3: While `line_busy` is 1, `core_ce` = `wait_en` AND NOT (`slot_use` OR `lut_use`).
- R4: While `line_busy` is 0, `core_ce` equals `wait_en`, whatever the values of `slot_use` and `lut_use`.
- R5: When the streamer drives `slot_use` at pixel phase 0 and `lut_use` at phase 1 mod N, `core_ce` is 0 on every line cycle for N of 1 or 2. For N of 3 or more, it is 1 on exactly `line_pixels` × (N-2) line cycles when `wait_en` is held at 1.
- R6: A `line_start` seen while busy, other than on the line's final cycle, is ignored. The length of the running line is unchanged.
- R7: A `line_start` with a nonzero count seen on the final cycle of a line starts the next line with no idle cycle between the two lines.
- R8: A `line_start` with `line_pixels` = 0 is ignored, and `line_busy` stays 0.
- R9: `wait_en` = 0 forces `core_ce` to 0, but the line keeps counting, so the line length does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_en | input | 1 | Existing wait/halt enable of the core |
| slot_use | input | 1 | Streamer holds the memory slot this cycle |
| lut_use | input | 1 | Streamer holds the lookup RAM bus this cycle |
| line_start | input | 1 | Start a video line |
| line_pixels | input | CNT_W | Pixel count of the line being started |
| div_n | input | DIV_W | Clocks per pixel (0 treated as 1) |
| core_ce | output | 1 | Clock enable for the core |
| line_busy | output | 1 | A video line is in progress |

## Verification
Two functions can act in the same cycle: the end of a line and the acceptance of a new start. The bench provokes this by pulsing `line_start` in exactly the last counted cycle of a line. It then checks that `line_busy` never drops and that the second line lasts exactly its own count × N cycles. The bench also pulses a start in the first cycle of a longer line and checks that the line length is unchanged, which shows that a start outside the final cycle is not taken.

// File: rtl/core_throttle.sv
module core_throttle #(
  parameter int CNT_W = 12,
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wait_en,
  input  logic             slot_use,
  input  logic             lut_use,
  input  logic             line_start,
  input  logic [CNT_W-1:0] line_pixels,
  input  logic [DIV_W-1:0] div_n,
  output logic             core_ce,
  output logic             line_busy
);

  logic             busy;
  logic [CNT_W-1:0] pix_left;
  logic [DIV_W-1:0] phase_max;
  logic [DIV_W-1:0] phase;

  wire pix_end  = busy && (phase == phase_max);
  wire line_end = pix_end && (pix_left == CNT_W'(1));
  wire accept   = line_start && (line_pixels != '0) && (!busy || line_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      pix_left  <= '0;
      phase_max <= '0;
      phase     <= '0;
    end else if (accept) begin
      busy      <= 1'b1;
      pix_left  <= line_pixels;
      phase_max <= (div_n == '0) ? '0 : div_n - DIV_W'(1);
      phase     <= '0;
    end else if (busy) begin
      if (pix_end) begin
        phase    <= '0;
        pix_left <= pix_left - CNT_W'(1);
        if (pix_left == CNT_W'(1)) busy <= 1'b0;
      end else begin
        phase <= phase + DIV_W'(1);
      end
    end
  end

  assign core_ce   = wait_en && !(busy && (slot_use || lut_use));
  assign line_busy = busy;

  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !line_busy);
  a_r2_start_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_busy && line_start && line_pixels != '0) |=> line_busy);
  a_r2_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pix_left != '0);
  a_r3_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (line_busy && (slot_use || lut_use)) |-> !core_ce);
  a_r4_idle_free: assert property (@(posedge clk) disable iff (!rst_n)
    !line_busy |-> core_ce == wait_en);
  a_r6_div_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !line_end) |=> $stable(phase_max));
  a_r8_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_busy && line_start && line_pixels == '0) |=> !line_busy);
  a_r9_wait_gates: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_en |-> !core_ce);

endmodule

// File: tb/core_throttle_test.sv
module core_throttle_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wait_en = 1;
  logic       slot_use = 0;
  logic       lut_use = 0;
  logic       line_start = 0;
  logic [11:0] line_pixels = '0;
  logic [4:0] div_n = '0;
  logic       core_ce, line_busy;

  int n_chk = 0;
  int n_bad = 0;
  int free_cnt;

  always #2.5 clk = ~clk;

  core_throttle uut (
    .clk(clk), .rst_n(rst_n), .wait_en(wait_en), .slot_use(slot_use),
    .lut_use(lut_use), .line_start(line_start), .line_pixels(line_pixels),
    .div_n(div_n), .core_ce(core_ce), .line_busy(line_busy)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_start(int n, int cnt);
    @(negedge clk);
    div_n = 5'(n);
    line_pixels = 12'(cnt);
    line_start = 1;
  endtask

  task automatic body(int n, int cnt, bit wmode, int poke_k, int poke_cnt);
    int neff = (n == 0) ? 1 : n;
    int lutp = (neff > 1) ? 1 : 0;
    free_cnt = 0;
    for (int k = 0; k < cnt * neff; k++) begin
      @(negedge clk);
      line_start = (k == poke_k);
      line_pixels = 12'(poke_cnt);
      slot_use = ((k % neff) == 0);
      lut_use = ((k % neff) == lutp);
      wait_en = wmode ? ((k % 3) != 2) : 1'b1;
      #1;
      chk((poke_k >= 0) ? "R6 busy held" : "R2 busy", line_busy, 1);
      chk(wmode ? "R9 gated ce" : "R3 ce", core_ce,
          int'(wait_en && !(slot_use || lut_use)));
      if (neff <= 2) chk("R5 full stall", core_ce, 0);
      if (core_ce) free_cnt++;
    end
    if (!wmode) chk("R5 free cycles", free_cnt, cnt * ((neff > 2) ? neff - 2 : 0));
  endtask

  task automatic idle_check(string req);
    @(negedge clk);
    line_start = 0;
    slot_use = 1;
    lut_use = 1;
    wait_en = 1;
    #1;
    chk(req, line_busy, 0);
    chk("R4 idle ce", core_ce, 1);
    wait_en = 0;
    #1;
    chk("R4 idle ce follows wait", core_ce, 0);
    slot_use = 0;
    lut_use = 0;
    wait_en = 1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R1 busy", line_busy, 0);
    chk("R1 ce", core_ce, 1);
    rst_n = 1;

    for (int n = 0; n <= 6; n++) begin
      for (int c = 1; c <= 4; c++) begin
        int neff = (n == 0) ? 1 : n;
        int pk = (c == 2 && c * neff > 1) ? 0 : -1;
        pulse_start(n, c);
        body(n, c, (c == 3), pk, 7);
        idle_check("R2 line end");
      end
    end

    for (int n = 1; n <= 5; n++) begin
      pulse_start(n, 2);
      body(n, 2, 0, 2 * n - 1, 3);
      body(n, 3, 0, -1, 0);
      idle_check("R7 back-to-back end");
    end

    pulse_start(3, 0);
    @(negedge clk);
    line_start = 0;
    #1;
    chk("R8 zero count", line_busy, 0);
    @(negedge clk);
    #1;
    chk("R8 zero count later", line_busy, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule